// File: doc/BRIEF.md
# Run-time Formatted Serial Transmitter

This block turns one parallel character into one asynchronous serial frame on a single output line. A character is offered on a valid/ready handshake together with its format: a 7- or 8-bit character, one or two stop bits, and a parity bit that can be left out or made even or odd. The block packs the whole frame at the moment the character is taken, so the format inputs can change freely while the frame is on the line.

Bit timing comes from outside. A one-cycle strobe marks each bit boundary, and the line moves only on that strobe. The strobe can come from any divider. While no frame is in flight, the line rests high and the block signals that it can take a character.

Top module: `uart_txf`

## Requirements
- R1: After reset and whenever no frame is in flight, `tx` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A character is taken on a clock edge where `in_valid` and `in_ready` are both 1. `tx` stays 1 until the first `bit_tick` edge after that. On that edge `tx` goes to 0 for the start bit, which lasts exactly one tick interval.
- R3: The data bits follow the start bit, least significant bit first. There are 8 of them when `cfg_len8` is 1 and 7 when it is 0.
- R4: When `cfg_len8` is 0, `in_data[7]` is not sent and has no effect on the parity bit.
- R5: Parity encoding (`cfg_par_en`, `cfg_par_odd`). When `cfg_par_en` is 0, no parity bit is sent, whatever `cfg_par_odd` is. The setting (1,0) gives even parity: the data bits that are sent plus the parity bit hold an even number of ones. The setting (1,1) gives odd parity: that count is odd.
- R6: When parity is enabled, the parity bit comes right after the last data bit and before the first stop bit.
- R7: Stop bits are 1 on the line. There is one stop bit when `cfg_stop2` is 0 and two when it is 1.
- R8: The data and format inputs are sampled only when a character is taken. Changes to them during a frame have no effect on that frame.
- R9: From the edge that takes a character until the frame ends, `busy` is 1 and `in_ready` is 0. Requests offered during that time are not taken.
- R10: `tx` changes only on edges where `bit_tick` is 1, so every bit lasts one tick interval. On the tick that ends the last stop bit, the block returns to the idle state of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle strobe marking each bit boundary |
| in_valid | input | 1 | A character is offered |
| in_data | input | DATA_W (8) | Character, bit 0 sent first |
| in_ready | output | 1 | A character can be taken |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one stop bit |
| cfg_par_en | input | 1 | 1: send a parity bit |
| cfg_par_odd | input | 1 | With parity on: 1 odd, 0 even |
| tx | output | 1 | Serial line |
| busy | output | 1 | A frame is in flight |

## Verification
The hardest case to reach from the ports is a frame that is already on the line while the inputs are moving. The inputs being a new request held valid, with different data and a different format, all of which must be ignored. The bench reaches this case in many frames by keeping `in_valid` high with scrambled data and format right after the acceptance edge. It drops the request only after the tick that ends the frame. Directed frames also cover all twelve format combinations, with data of only bit 7 set in 7-bit mode, where a leak of that bit would change both the length of the frame and its parity.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;
  typedef struct packed {
    logic len8;
    logic stop2;
    logic par_en;
    logic par_odd;
  } txf_fmt_t;
endpackage

// File: rtl/uart_txf_parity.sv
module uart_txf_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              full_len,
  input  logic              odd,
  output logic              par_bit
);
  logic [DATA_W-1:0] used;

  // the top bit only counts in full-length mode
  always_comb begin
    used = data;
    if (!full_len) used[DATA_W-1] = 1'b0;
    par_bit = (^used) ^ odd;
  end
endmodule

// File: rtl/uart_txf_framer.sv
module uart_txf_framer
  import uart_txf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FW     = DATA_W + 4,
  parameter int CW     = $clog2(FW + 1)
) (
  input  logic [DATA_W-1:0] data,
  input  txf_fmt_t          fmt,
  output logic [FW-1:0]     frame,
  output logic [CW-1:0]     nbits
);
  logic          par_bit;
  logic [FW-1:0] dpad;
  int            dlen;

  uart_txf_parity #(.DATA_W(DATA_W)) u_par (
    .data     (data),
    .full_len (fmt.len8),
    .odd      (fmt.par_odd),
    .par_bit  (par_bit)
  );

  assign dpad = FW'(data);

  // position 0 is the start bit; the rest fill in send order
  always_comb begin
    dlen = fmt.len8 ? DATA_W : DATA_W - 1;
    for (int i = 0; i < FW; i++) begin
      if (i == 0)                          frame[i] = 1'b0;
      else if (i <= dlen)                  frame[i] = dpad[i-1];
      else if (fmt.par_en && i == dlen + 1) frame[i] = par_bit;
      else                                 frame[i] = 1'b1;
    end
    nbits = CW'(1 + dlen + (fmt.par_en ? 1 : 0) + (fmt.stop2 ? 2 : 1));
  end
endmodule

// File: rtl/uart_txf_shifter.sv
module uart_txf_shifter #(
  parameter int FW = 12,
  parameter int CW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_tick,
  input  logic          load,
  input  logic [FW-1:0] frame_in,
  input  logic [CW-1:0] nbits_in,
  output logic          tx,
  output logic          busy
);
  logic [FW-1:0] sreg;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '1;
      left <= '0;
      tx   <= 1'b1;
      busy <= 1'b0;
    end else if (load && !busy) begin
      sreg <= frame_in;
      left <= nbits_in;
      busy <= 1'b1;
    end else if (busy && bit_tick) begin
      if (left != '0) begin
        tx   <= sreg[0];
        sreg <= {1'b1, sreg[FW-1:1]};
        left <= left - 1'b1;
      end else begin
        busy <= 1'b0;
        tx   <= 1'b1;
      end
    end
  end

  AST_LINE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(tx)); // R10
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx); // R1
  AST_END_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> tx && $past(bit_tick)); // R10
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy); // R9
endmodule

// File: rtl/uart_txf.sv
module uart_txf
  import uart_txf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              cfg_len8,
  input  logic              cfg_stop2,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  output logic              tx,
  output logic              busy
);
  localparam int FW = DATA_W + 4;
  localparam int CW = $clog2(FW + 1);

  txf_fmt_t      fmt;
  logic [FW-1:0] frame;
  logic [CW-1:0] nbits;
  logic          accept;

  assign fmt      = '{len8: cfg_len8, stop2: cfg_stop2,
                      par_en: cfg_par_en, par_odd: cfg_par_odd};
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  uart_txf_framer #(.DATA_W(DATA_W), .FW(FW), .CW(CW)) u_framer (
    .data  (in_data),
    .fmt   (fmt),
    .frame (frame),
    .nbits (nbits)
  );

  uart_txf_shifter #(.FW(FW), .CW(CW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .load     (accept),
    .frame_in (frame),
    .nbits_in (nbits),
    .tx       (tx),
    .busy     (busy)
  );

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy && !in_ready); // R9
  AST_START_WAITS_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> tx); // R2
endmodule

// File: tb/uart_txf_tb.sv
module uart_txf_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic cfg_len8 = 1'b0, cfg_stop2 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic tx, busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int tdiv = 0;

  always #2 clk = ~clk;

  uart_txf #(.DATA_W(8)) u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .cfg_len8(cfg_len8),
    .cfg_stop2(cfg_stop2), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .tx(tx), .busy(busy)
  );

  // bit strobe: one cycle high out of four
  always @(negedge clk) begin
    tdiv     <= (tdiv == 3) ? 0 : tdiv + 1;
    bit_tick <= (tdiv == 3) && !rst;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected line sequence, built from the requirements
  function automatic int expect_frame(input logic [7:0] d, input logic [3:0] f,
                                      output logic [15:0] bits, output logic [15:0] kind4);
    int n = 0;
    int ones = 0;
    int dl = f[3] ? 8 : 7;
    bits = '1; kind4 = '0;
    bits[n] = 1'b0; n++;
    for (int i = 0; i < dl; i++) begin
      bits[n] = d[i]; ones += d[i]; kind4[n] = !f[3]; n++;
    end
    if (f[1]) begin
      bits[n] = f[0] ? ~ones[0] : ones[0]; n++;
    end
    n += f[2] ? 2 : 1;
    return n;
  endfunction

  // f = {len8, stop2, par_en, par_odd}
  task automatic send(input logic [7:0] d, input logic [3:0] f, input bit scramble);
    logic [15:0] bits, kind4;
    int n, dl, pp;
    bit hold_ok = 1;
    string pre;
    n  = expect_frame(d, f, bits, kind4);
    dl = f[3] ? 8 : 7;
    pp = 1 + dl;
    pre = scramble ? "R8 " : "";
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d;
    {cfg_len8, cfg_stop2, cfg_par_en, cfg_par_odd} = f;
    @(posedge clk);
    @(negedge clk);
    if (scramble) begin
      in_data = 8'($urandom);
      {cfg_len8, cfg_stop2, cfg_par_en, cfg_par_odd} = 4'($urandom);
    end else in_valid = 1'b0;
    chk("R9 ready low after accept", in_ready, 0);
    chk("R9 busy after accept", busy, 1);
    chk("R2 line high before first tick", tx, 1);
    for (int k = 0; k <= n; k++) begin
      forever begin
        @(posedge clk);
        if (bit_tick) break;
        @(negedge clk);
        if (k > 0 && tx !== bits[k-1]) hold_ok = 0;
        if (scramble && k > 0 && k < n) begin
          in_data = 8'($urandom);
          {cfg_len8, cfg_stop2, cfg_par_en, cfg_par_odd} = 4'($urandom);
        end
      end
      @(negedge clk);
      if (k < n) begin
        string tag;
        if (k == 0) tag = "R2 start bit";
        else if (k <= dl) tag = kind4[k] ? "R3 R4 seven-bit data" : "R3 data bit";
        else if (f[1] && k == pp) tag = "R5 R6 parity bit";
        else tag = "R7 stop bit";
        chk({pre, tag}, tx, bits[k]);
        if (k > 0 && k < n - 1) chk("R9 ready stays low", in_ready, 0);
      end else begin
        in_valid = 1'b0;
        chk("R10 idle after last stop", busy, 0);
        chk("R1 ready back", in_ready, 1);
        chk("R1 line high idle", tx, 1);
        chk("R10 bits held between ticks", hold_ok, 1);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    chk("R1 reset tx", tx, 1);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset ready", in_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", tx, 1);
    for (int f = 0; f < 16; f++) begin
      send(8'h80, 4'(f), 0);
      send(8'h7F, 4'(f), 0);
    end
    send(8'hFF, 4'b0011, 0);
    send(8'h00, 4'b1011, 0);
    send(8'h80, 4'b0010, 1);
    send(8'h55, 4'b1111, 1);
    for (int r = 0; r < 60; r++)
      send(8'($urandom), 4'($urandom), bit'($urandom));
    repeat (10) @(negedge clk);
    chk("R1 final idle", tx, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule